// File: doc/BRIEF.md
# Bit-Pipelined Ripple Carry Adder

This block adds two unsigned operands and a carry input, with a register on the carry at every bit position. Each bit position is its own pipeline stage. Operand bit i is held back by i cycles, so that it reaches its full adder in the same cycle as the registered carry from bit i-1. Sum bit i is then held for WIDTH-1-i more cycles, so that every sum bit and the carry-out leave together.

Logic depth per cycle is a single full adder, whatever the width. A new operand pair can enter on every clock cycle, and once the pipe is full one complete result leaves per cycle. The cost is latency, which equals WIDTH cycles. A valid tag travels beside the data through a WIDTH-stage shift chain, so that a downstream block knows which output cycles carry real results. The datapath runs freely and does not depend on the tag.

Top module: `bitpipe_adder`

## Requirements
- R1: When out_valid is 1, {carry_out, sum} equals op_a + op_b + carry_in, all taken as unsigned, for the operands presented exactly WIDTH cycles earlier.
- R2: out_valid equals the in_valid sampled WIDTH rising edges earlier, including gaps where in_valid is 0. The edge that captures the inputs counts as the first of these.
- R3: The block takes a new operand set on every rising edge. A run of consecutive valid inputs gives the same number of consecutive valid results, each with its own correct sum.
- R4: While rst_n is 0, out_valid, sum and carry_out are 0. Reset asserts without waiting for a clock. For the first WIDTH cycles after release, out_valid stays 0 and sum and carry_out stay 0.
- R5: A carry that ripples across every bit is still correct. With WIDTH=4: all-ones + all-ones + 1 gives sum 4'hF, carry_out 1. 0 + all-ones + 1 gives sum 0, carry_out 1. All-ones + 0 + 0 gives sum 4'hF, carry_out 0.
- R6: With WIDTH=1 the block is a single registered full adder with a latency of one cycle, and R1 and R2 hold for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| in_valid | input | 1 | Marks the current operands as a real request |
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Marks sum and carry_out as a real result |
| sum | output | WIDTH | Aligned sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies side by side from one stimulus stream. One uses the default WIDTH=4, which has three skew depths, three deskew depths and the full four-stage carry ripple. The other uses WIDTH=1, where every skew and deskew line drops out and only the registered full adder and one valid stage remain. Together they cover the deepest alignment paths at a practical width and the degenerate case where the generate branches remove the delay lines. Random operands with random valid gaps exercise the tag and data alignment, while directed all-ones and zero-plus-ones cases drive a carry through every stage.

// File: rtl/bpa_pkg.sv
`timescale 1ns/1ps
package bpa_pkg;

  // Result of one bit-slice addition: sum bit and carry bit.
  typedef struct packed {
    logic co;
    logic s;
  } fa_res_t;

  // One-bit full adder written as parity and majority.
  function automatic fa_res_t fa_eval(input logic a, input logic b, input logic c);
    fa_res_t r;
    r.s  = a ^ b ^ c;
    r.co = (a & b) | (a & c) | (b & c);
    return r;
  endfunction

endpackage

// File: rtl/bpa_delay.sv
`timescale 1ns/1ps
// Fixed-depth shift line used for operand skew, sum deskew and the valid tag.
// DEPTH must be at least 1; the top omits the instance where the delay is zero.
module bpa_delay #(
  parameter int DEPTH = 1,
  parameter int W     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = DEPTH - 1;

  logic [W-1:0] stg_q   [DEPTH];
  logic [W-1:0] stg_nxt [DEPTH];

  // next-state
  always_comb begin
    stg_nxt[0] = d;
    for (int k = 1; k < DEPTH; k++) begin
      stg_nxt[k] = stg_q[k-1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        stg_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        stg_q[k] <= stg_nxt[k];
      end
    end
  end

  assign q = stg_q[LAST];

  AST_DELAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stg_q[0] == $past(d))); // R2

endmodule

// File: rtl/bpa_fa_stage.sv
`timescale 1ns/1ps
// One pipeline stage: a full adder with registered sum and carry.
module bpa_fa_stage
  import bpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum_q,
  output logic carry_q
);

  fa_res_t res_nxt;

  // next-state
  always_comb begin
    res_nxt = fa_eval(a, b, cin);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= res_nxt.s;
      carry_q <= res_nxt.co;
    end
  end

  AST_STAGE_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ({carry_q, sum_q} ==
      (2'($past(a)) + 2'($past(b)) + 2'($past(cin))))); // R1

endmodule

// File: rtl/bitpipe_adder.sv
`timescale 1ns/1ps
// Bit-pipelined ripple carry adder: one bit per stage, skewed operand
// inputs, deskewed sum outputs, WIDTH cycles of latency.
module bitpipe_adder #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  localparam int LAT = WIDTH;
  localparam int CW  = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] a_sk;
  logic [WIDTH-1:0] b_sk;
  logic [WIDTH-1:0] c_in_bit;
  logic [WIDTH-1:0] s_reg;
  logic [WIDTH-1:0] c_reg;

  assign c_in_bit[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // operand skew: bit i waits i cycles for the carry from bit i-1
    if (i == 0) begin : g_noskew
      assign a_sk[i] = op_a[i];
      assign b_sk[i] = op_b[i];
    end else begin : g_skew
      logic [1:0] ab_q;
      bpa_delay #(.DEPTH(i), .W(2)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({op_a[i], op_b[i]}),
        .q     (ab_q)
      );
      assign a_sk[i] = ab_q[1];
      assign b_sk[i] = ab_q[0];
      assign c_in_bit[i] = c_reg[i-1];
    end

    bpa_fa_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .a       (a_sk[i]),
      .b       (b_sk[i]),
      .cin     (c_in_bit[i]),
      .sum_q   (s_reg[i]),
      .carry_q (c_reg[i])
    );

    // sum deskew: bit i waits WIDTH-1-i more cycles
    if (i == WIDTH - 1) begin : g_nodeskew
      assign sum[i] = s_reg[i];
    end else begin : g_deskew
      bpa_delay #(.DEPTH(WIDTH - 1 - i), .W(1)) u_deskew (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (s_reg[i]),
        .q     (sum[i])
      );
    end
  end

  assign carry_out = c_reg[WIDTH-1];

  // valid tag follows the data through LAT stages
  bpa_delay #(.DEPTH(LAT), .W(1)) u_vtag (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_valid),
    .q     (out_valid)
  );

  // Fill counter for checking only: edges seen since reset, saturating.
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_nxt;

  always_comb begin
    fill_nxt = (fill_q == CW'(LAT)) ? fill_q : fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_nxt;
  end

  AST_FILL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_q >= CW'(LAT))); // R4

  AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$isunknown({out_valid, sum, carry_out})); // R4

endmodule

// File: tb/sim_bitpipe_adder.sv
`timescale 1ns/1ps
module sim_bitpipe_adder;

  localparam int WA = 4;
  localparam int WB = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic [WA-1:0] op_a;
  logic [WA-1:0] op_b;
  logic          carry_in;

  logic          ov4, co4;
  logic [WA-1:0] s4;
  logic          ov1, co1;
  logic [WB-1:0] s1;

  bitpipe_adder #(.WIDTH(WA)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .out_valid(ov4), .sum(s4), .carry_out(co4)
  );

  bitpipe_adder #(.WIDTH(WB)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a[0]), .op_b(op_b[0]),
    .carry_in(carry_in), .out_valid(ov1), .sum(s1), .carry_out(co1)
  );

  // history of driven inputs, indexed by cycle modulo 16
  logic          hv [16];
  logic [WA-1:0] ha [16];
  logic [WA-1:0] hb [16];
  logic          hc [16];
  string         hr [16];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  function automatic logic [WA:0] ref_add4(logic [WA-1:0] a, logic [WA-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{WA{1'b0}}, c};
  endfunction

  function automatic logic [1:0] ref_add1(logic a, logic b, logic c);
    return {1'b0, a} + {1'b0, b} + {1'b0, c};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // compare outputs against the inputs of WIDTH cycles ago, then drive new inputs
  task automatic step(logic v, logic [WA-1:0] a, logic [WA-1:0] b, logic c, string req);
    @(negedge clk);
    begin
      int i4 = (cyc + 16 - WA) % 16;
      int i1 = (cyc + 16 - WB) % 16;
      logic [WA:0] e4 = ref_add4(ha[i4], hb[i4], hc[i4]);
      logic [1:0]  e1 = ref_add1(ha[i1][0], hb[i1][0], hc[i1]);
      if (cyc < WA) begin
        chk({ov4, s4, co4} == '0, "R4 fill quiet", 32'({ov4, s4, co4}), 32'd0);
      end
      chk(ov4 == hv[i4], "R2 valid latency", 32'(ov4), 32'(hv[i4]));
      if (hv[i4]) chk({co4, s4} == e4, hr[i4], 32'({co4, s4}), 32'(e4));
      chk(ov1 == hv[i1], "R6 valid latency w1", 32'(ov1), 32'(hv[i1]));
      if (hv[i1]) chk({co1, s1} == e1, "R6 sum w1", 32'({co1, s1}), 32'(e1));
    end
    hv[cyc % 16] = v; ha[cyc % 16] = a; hb[cyc % 16] = b;
    hc[cyc % 16] = c; hr[cyc % 16] = req;
    in_valid = v; op_a = a; op_b = b; carry_in = c;
    cyc++;
  endtask

  initial begin
    void'($urandom(32'd2417));
    for (int k = 0; k < 16; k++) begin
      hv[k] = 1'b0; ha[k] = '0; hb[k] = '0; hc[k] = 1'b0; hr[k] = "R1";
    end
    rst_n = 1'b0;
    in_valid = 1'b1; op_a = 4'hF; op_b = 4'hF; carry_in = 1'b1;
    // R4: reset holds outputs at zero even with active inputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({ov4, s4, co4} == '0, "R4 reset clear", 32'({ov4, s4, co4}), 32'd0);
      chk({ov1, s1, co1} == '0, "R4 reset clear w1", 32'({ov1, s1, co1}), 32'd0);
    end
    in_valid = 1'b0; op_a = '0; op_b = '0; carry_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R5: carries rippling across all bits
    step(1'b1, 4'hF, 4'hF, 1'b1, "R5 ones+ones+1");
    step(1'b1, 4'h0, 4'hF, 1'b1, "R5 zero+ones+1");
    step(1'b1, 4'hF, 4'h0, 1'b0, "R5 ones+zero");
    step(1'b0, 4'h5, 4'hA, 1'b1, "R2 bubble");
    step(1'b1, 4'h0, 4'h0, 1'b0, "R5 zeros");
    // R3: back-to-back burst of valid operands
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 4'(k), 4'(15 - k), 1'(k & 1), "R3 burst");
    end
    // R1/R2: random operands with random gaps
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom_range(3) != 0), 4'($urandom), 4'($urandom), 1'($urandom), "R1 random");
    end
    // drain
    for (int k = 0; k < WA + 1; k++) begin
      step(1'b0, '0, '0, 1'b0, "R2 drain");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule